// File: doc/BRIEF.md
# Dual-Channel Single-Bin DFT Engine

This block evaluates one discrete Fourier coefficient, at a single chosen bin, for two sampled channels at the same time. One channel carries a signal proportional to the voltage across the object under test. The other carries a signal proportional to the current through it. Both channels share one valid strobe and one sample index from the acquisition timing logic. Since acquisition is coherent, the tone falls exactly on the selected bin, so no full transform is needed. One twiddle lookup per sample feeds all four multiply-accumulate paths.

A record begins with a `start` pulse. The pulse clears the accumulators and latches the bin number and the record length. The record length is N = 2^`rec_log2`. For each accepted sample with index n, the engine adds x[n]·cos(2π·l·n/N) to the real sum and subtracts x[n]·sin(2π·l·n/N) from the imaginary sum. Both twiddles come from a scaled cosine/sine table. When the sample with index N−1 has passed through the pipeline, `res_valid` pulses and the four sums hold steady until the next start. Software then forms the impedance ratio, the modulus, the argument and any correction.

Top module: `dft_bin_engine`

## Requirements
- R1: For each channel, the real output equals Σ x[n]·C[a(n)] and the imaginary output equals −Σ x[n]·S[a(n)], summed over accepted samples. C[a] and S[a] are round(32767·cos(2πa/256)) and round(32767·sin(2πa/256)).
- R2: The table address a(n) is bits [15:8] of ((l·n) mod N)·(65536/N), with N = 2^rec_log2 and rec_log2 from 0 to 16. A bin l ≥ N therefore aliases onto l mod N. For N=4, l=3 flips the sign of the imaginary part relative to l=1.
- R3: Each accumulator is 48 bits signed. A record of N=65536 full-scale samples (−32768 or +32767) at bin 0 gives the exact sum without overflow.
- R4: `start` sets all four outputs to zero at the next clock edge. It latches `bin_sel` and `rec_log2`, and later changes on those inputs have no effect within the record.
- R5: `res_valid` is a one-cycle pulse. It is high in the third cycle after the clock edge that accepts the sample whose index equals N−1.
- R6: Samples with `smp_valid` high are ignored outside a record: before the first `start`, and after the last sample until the next `start`. The outputs stay unchanged.
- R7: Cycles with `smp_valid` low are skipped. A record with idle gaps gives the same sums as one without gaps.
- R8: For a pure tone A·cos(2π·l·n/N+φ) at the selected bin, the coefficient is N·A·32767/2·(cos φ + j·sin φ). At a different bin the coefficient is near zero, within N·(A+32767)/2.
- R9: The two channels accumulate independently: each channel's sums depend only on its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a record: clear sums, latch bin and length |
| bin_sel | input | 16 | Bin number l |
| rec_log2 | input | 5 | Record length exponent, N = 2^rec_log2 |
| smp_valid | input | 1 | Sample pair strobe |
| smp_idx | input | 16 | Sample index n within the record |
| u_smp | input | 16 | Signed voltage-channel sample |
| i_smp | input | 16 | Signed current-channel sample |
| res_valid | output | 1 | One-cycle pulse when the sums are final |
| u_re | output | 48 | Voltage channel real sum |
| u_im | output | 48 | Voltage channel imaginary sum |
| i_re | output | 48 | Current channel real sum |
| i_im | output | 48 | Current channel imaginary sum |

## Verification
A wrong table address or twiddle sign shows at the ports only when `res_valid` pulses. In that cycle the real and imaginary parts come out swapped or negated, or the tone energy lands on a neighbouring bin. Short records with exact integer results, such as the four-point record and the constant input at bin 0, expose these errors after a few cycles. A record-state fault shows directly on the pins. A missed end of record leaves `res_valid` silent. A failure to latch at start, or leaking samples, changes the held sums in the cycles after the pulse. A truncated accumulator shows only in the long full-scale record, when the final pulse arrives after 65536 samples.

// File: rtl/dft_pkg.sv
`timescale 1ns/1ps
package dft_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded table entry: scale * cos or sin of (2*pi*idx / 2^aw).
  function automatic int tw_value(input int idx, input int aw, input int scale,
                                  input bit want_sin);
    real ang;
    real v;
    ang = TWO_PI * real'(idx) / real'(1 << aw);
    v   = want_sin ? $sin(ang) : $cos(ang);
    if (v >= 0.0) return  $rtoi(v * real'(scale) + 0.5);
    else          return -$rtoi(-v * real'(scale) + 0.5);
  endfunction

  // Phase in turn units of 2^width: (bin*idx) scaled by 2^shift; the caller
  // keeps the low bits, which is exactly the wrap modulo the record length.
  function automatic int unsigned phase_turn(input int unsigned bin,
                                             input int unsigned idx,
                                             input int unsigned shift);
    int unsigned prod;
    prod = bin * idx;
    return prod << shift;
  endfunction

endpackage

// File: rtl/dft_twiddle_rom.sv
`timescale 1ns/1ps
module dft_twiddle_rom #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic [AW-1:0]        addr,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o
);
  localparam int DEPTH = 1 << AW;
  localparam int SCALE = (1 << (CW - 1)) - 1;

  logic signed [CW-1:0] cos_tab [DEPTH];
  logic signed [CW-1:0] sin_tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int CV = dft_pkg::tw_value(k, AW, SCALE, 1'b0);
    localparam int SV = dft_pkg::tw_value(k, AW, SCALE, 1'b1);
    assign cos_tab[k] = CW'(CV);
    assign sin_tab[k] = CW'(SV);
  end

  assign cos_o = cos_tab[addr];
  assign sin_o = sin_tab[addr];
endmodule

// File: rtl/dft_mac_lane.sv
`timescale 1ns/1ps
module dft_mac_lane #(
  parameter int SW    = 16,
  parameter int CW    = 16,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [SW-1:0]    x,
  input  logic signed [CW-1:0]    c,
  input  logic signed [CW-1:0]    s,
  output logic signed [ACC_W-1:0] acc_re,
  output logic signed [ACC_W-1:0] acc_im
);
  localparam int PW = SW + CW;

  logic signed [PW-1:0] xe, ce, se;
  logic signed [PW-1:0] p_re, p_im;
  logic                 p_vld;

  assign xe = {{CW{x[SW-1]}}, x};
  assign ce = {{SW{c[CW-1]}}, c};
  assign se = {{SW{s[CW-1]}}, s};

  // Product stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld <= 1'b0;
      p_re  <= '0;
      p_im  <= '0;
    end else begin
      p_vld <= in_vld & ~clr;
      p_re  <= xe * ce;
      p_im  <= xe * se;
    end
  end

  // Accumulate stage: real adds x*cos, imaginary subtracts x*sin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (clr) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (p_vld) begin
      acc_re <= acc_re + {{(ACC_W-PW){p_re[PW-1]}}, p_re};
      acc_im <= acc_im - {{(ACC_W-PW){p_im[PW-1]}}, p_im};
    end
  end
endmodule

// File: rtl/dft_bin_engine.sv
`timescale 1ns/1ps
module dft_bin_engine #(
  parameter int SMP_W  = 16,
  parameter int TW_W   = 16,
  parameter int IDX_W  = 16,
  parameter int LUT_AW = 8,
  parameter int LOG_W  = $clog2(IDX_W + 1),
  parameter int ACC_W  = SMP_W + TW_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        bin_sel,
  input  logic [LOG_W-1:0]        rec_log2,
  input  logic                    smp_valid,
  input  logic [IDX_W-1:0]        smp_idx,
  input  logic signed [SMP_W-1:0] u_smp,
  input  logic signed [SMP_W-1:0] i_smp,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] u_re,
  output logic signed [ACC_W-1:0] u_im,
  output logic signed [ACC_W-1:0] i_re,
  output logic signed [ACC_W-1:0] i_im
);
  localparam int NCH = 2;

  // Record state, latched on start
  logic              rec_active;
  logic [IDX_W-1:0]  bin_q;
  logic [LOG_W-1:0]  log2_q;

  // Named internal events
  logic              accept;
  logic              last_accept;
  logic [IDX_W:0]    last_idx;
  logic [LOG_W-1:0]  tw_shift;
  logic [IDX_W-1:0]  turn;
  logic [LUT_AW-1:0] tw_addr;
  logic signed [TW_W-1:0] tw_cos, tw_sin;

  assign accept      = smp_valid & rec_active & ~start;
  assign last_idx    = ((IDX_W+1)'(1) << log2_q) - (IDX_W+1)'(1);
  assign last_accept = accept & ({1'b0, smp_idx} == last_idx);
  assign tw_shift    = (log2_q > LOG_W'(IDX_W)) ? '0 : (LOG_W'(IDX_W) - log2_q);
  assign turn        = IDX_W'(dft_pkg::phase_turn(32'(bin_q), 32'(smp_idx), 32'(tw_shift)));
  assign tw_addr     = turn[IDX_W-1 -: LUT_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_active <= 1'b0;
      bin_q      <= '0;
      log2_q     <= '0;
    end else if (start) begin
      rec_active <= 1'b1;
      bin_q      <= bin_sel;
      log2_q     <= rec_log2;
    end else if (last_accept) begin
      rec_active <= 1'b0;
    end
  end

  dft_twiddle_rom #(.AW(LUT_AW), .CW(TW_W)) u_rom (
    .addr  (tw_addr),
    .cos_o (tw_cos),
    .sin_o (tw_sin)
  );

  // Stage 1: registered samples and twiddles
  logic                   s1_vld, s1_last;
  logic signed [SMP_W-1:0] s1_x [NCH];
  logic signed [TW_W-1:0]  s1_cos, s1_sin;
  logic                    s2_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_x[0] <= '0;
      s1_x[1] <= '0;
      s1_cos  <= '0;
      s1_sin  <= '0;
    end else begin
      s1_vld  <= accept;
      s1_last <= last_accept;
      s1_x[0] <= u_smp;
      s1_x[1] <= i_smp;
      s1_cos  <= tw_cos;
      s1_sin  <= tw_sin;
    end
  end

  // Completion pulse follows the last sample through the lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_last   <= 1'b0;
      res_valid <= 1'b0;
    end else if (start) begin
      s2_last   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      s2_last   <= s1_vld & s1_last;
      res_valid <= s2_last;
    end
  end

  logic signed [ACC_W-1:0] lane_re [NCH];
  logic signed [ACC_W-1:0] lane_im [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    dft_mac_lane #(.SW(SMP_W), .CW(TW_W), .ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .in_vld (s1_vld),
      .x      (s1_x[ch]),
      .c      (s1_cos),
      .s      (s1_sin),
      .acc_re (lane_re[ch]),
      .acc_im (lane_im[ch])
    );
  end

  assign u_re = lane_re[0];
  assign u_im = lane_im[0];
  assign i_re = lane_re[1];
  assign i_im = lane_im[1];
endmodule

// File: rtl/dft_bin_engine_chk.sv
`timescale 1ns/1ps
module dft_bin_engine_chk #(
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             last_accept,
  input logic             res_valid,
  input logic [ACC_W-1:0] u_re,
  input logic [ACC_W-1:0] u_im,
  input logic [ACC_W-1:0] i_re,
  input logic [ACC_W-1:0] i_im
);
  logic holding;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         holding <= 1'b0;
    else if (start)     holding <= 1'b0;
    else if (res_valid) holding <= 1'b1;
  end

  // R4: start clears every sum at the next edge
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (u_re == '0 && u_im == '0 && i_re == '0 && i_im == '0));

  // R5: completion is a single-cycle pulse
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: the pulse comes three cycles after the last sample is taken
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(last_accept, 3));

  // R6: after the pulse, sums stay put until the next start
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !start) |=> ($stable(u_re) && $stable(u_im) &&
                             $stable(i_re) && $stable(i_im)));
endmodule

bind dft_bin_engine dft_bin_engine_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .last_accept (last_accept),
  .res_valid   (res_valid),
  .u_re        (u_re),
  .u_im        (u_im),
  .i_re        (i_re),
  .i_im        (i_im)
);

// File: tb/sim_dft_bin_engine.sv
`timescale 1ns/1ps
module sim_dft_bin_engine;
  localparam real PI2 = 6.283185307179586;
  localparam real SC  = 32767.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] bin_sel = '0;
  logic [4:0]  rec_log2 = '0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_idx = '0;
  logic signed [15:0] u_smp = '0, i_smp = '0;
  logic res_valid;
  logic signed [47:0] u_re, u_im, i_re, i_im;

  always #2 clk = ~clk;

  dft_bin_engine u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int v_buf [65536];
  int i_buf [65536];

  typedef struct {
    real ure, uim, ire, iim, tol;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input real act, input real exp, input real tol);
    n_chk++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      n_fail++;
      $display("FAIL %s: actual %0.1f expected %0.1f (tol %0.1f)", tag, act, exp, tol);
    end
  endtask

  function automatic real r(input logic signed [47:0] v);
    return real'(longint'(v));
  endfunction

  task automatic push_exp(input real ure, input real uim, input real ire, input real iim,
                          input real tol, input string tag);
    exp_t e;
    e.ure = ure; e.uim = uim; e.ire = ire; e.iim = iim; e.tol = tol; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pop and compare on every completion pulse
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: unexpected res_valid, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " u_re"}, r(u_re), e.ure, e.tol);
        check({e.tag, " u_im"}, r(u_im), e.uim, e.tol);
        check({e.tag, " i_re"}, r(i_re), e.ire, e.tol);
        check({e.tag, " i_im"}, r(i_im), e.iim, e.tol);
      end
    end
  end

  // Driver: one record from v_buf/i_buf; gap>0 inserts an idle cycle every gap samples
  task automatic drive_record(input int lg, input int bin, input int gap, input bit chk_clr);
    int n;
    int lat;
    n = 1 << lg;
    @(negedge clk);
    start = 1'b1; bin_sel = 16'(bin); rec_log2 = 5'(lg);
    @(negedge clk);
    start = 1'b0;
    bin_sel = 16'(bin + 5); rec_log2 = 5'(lg == 16 ? 3 : lg + 1); // R4: ignored mid-record
    if (chk_clr) begin
      check("R4 clear u_re", r(u_re), 0.0, 0.0);
      check("R4 clear i_im", r(i_im), 0.0, 0.0);
    end
    for (int k = 0; k < n; k++) begin
      if (gap > 0 && k % gap == 1) begin
        smp_valid = 1'b0; smp_idx = 16'(n - 1); u_smp = 16'sd9999; i_smp = -16'sd9999;
        @(negedge clk);
      end
      smp_valid = 1'b1; smp_idx = 16'(k);
      u_smp = 16'(v_buf[k]); i_smp = 16'(i_buf[k]);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check("R5 latency", real'(lat), 3.0, 0.0);
  endtask

  task automatic fill_tone(input int lg, input int l, input real au, input real pu,
                           input real ai, input real pi_);
    int n;
    n = 1 << lg;
    for (int k = 0; k < n; k++) begin
      v_buf[k] = $rtoi($floor(au * $cos(PI2 * l * k / n + pu) + 0.5));
      i_buf[k] = $rtoi($floor(ai * $cos(PI2 * l * k / n + pi_) + 0.5));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    real t, snap;
    repeat (3) @(negedge clk);
    // Reset state
    check("reset res_valid", real'(res_valid), 0.0, 0.0);
    check("reset u_re", r(u_re), 0.0, 0.0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: samples before any start are ignored
    for (int k = 0; k < 6; k++) begin
      smp_valid = 1'b1; smp_idx = 16'(k % 2); u_smp = 16'sd1000; i_smp = 16'sd2000;
      rec_log2 = 5'd1;
      @(negedge clk);
      check("R6 pre-start res_valid", real'(res_valid), 0.0, 0.0);
    end
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 pre-start u_re", r(u_re), 0.0, 0.0);
    check("R6 pre-start i_re", r(i_re), 0.0, 0.0);

    // R1/R2: four-point record, l=1: re = S(a-c), im = -S(b-d)
    v_buf[0] = 100; v_buf[1] = -7; v_buf[2] = 30; v_buf[3] = 50;
    i_buf[0] = -2000; i_buf[1] = 300; i_buf[2] = 1000; i_buf[3] = -40;
    push_exp(SC*70, -SC*(-57), SC*(-3000), -SC*340, 0.0, "R1 N4 l1");
    drive_record(2, 1, 0, 1'b1);
    // R2: l=3 flips the imaginary sign
    push_exp(SC*70, SC*(-57), SC*(-3000), SC*340, 0.0, "R2 N4 l3");
    drive_record(2, 3, 0, 1'b0);
    // R2: l=5 aliases onto l=1
    push_exp(SC*70, -SC*(-57), SC*(-3000), -SC*340, 0.0, "R2 N4 l5 alias");
    drive_record(2, 5, 0, 1'b0);

    // R9/R1: constants at bin 0, distinct per channel, N=32
    for (int k = 0; k < 32; k++) begin v_buf[k] = 1234; i_buf[k] = -321; end
    push_exp(SC*1234*32, 0.0, SC*(-321)*32, 0.0, 0.0, "R9 dc");
    drive_record(5, 0, 0, 1'b0);
    // R7: same record with idle gaps
    push_exp(SC*1234*32, 0.0, SC*(-321)*32, 0.0, 0.0, "R7 gaps");
    drive_record(5, 0, 3, 1'b0);

    // R6: extra samples after the record leave sums unchanged
    snap = r(u_re);
    for (int k = 0; k < 5; k++) begin
      smp_valid = 1'b1; smp_idx = 16'(31); u_smp = 16'sd5000; i_smp = 16'sd5000;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 hold u_re", r(u_re), snap, 0.0);
    check("R6 hold res_valid", real'(res_valid), 0.0, 0.0);

    // R8: tone at the evaluated bin, N=128, l=7
    fill_tone(7, 7, 12000.0, 0.6, 5000.0, -1.1);
    t = 128.0 * (12000.0 + SC) / 2.0;
    push_exp(128*12000.0*SC/2*$cos(0.6), 128*12000.0*SC/2*$sin(0.6),
             128*5000.0*SC/2*$cos(-1.1), 128*5000.0*SC/2*$sin(-1.1), t, "R8 tone match");
    drive_record(7, 7, 0, 1'b0);
    // R8: tone at bin 5 but evaluated at bin 9, N=64
    fill_tone(6, 5, 15000.0, 0.3, 15000.0, 2.0);
    t = 64.0 * (15000.0 + SC) / 2.0;
    push_exp(0.0, 0.0, 0.0, 0.0, t, "R8 tone mismatch");
    drive_record(6, 9, 0, 1'b0);
    // R8: N=256 tone at l=40
    fill_tone(8, 40, 9000.0, -2.5, 20000.0, 1.3);
    t = 256.0 * (20000.0 + SC) / 2.0;
    push_exp(256*9000.0*SC/2*$cos(-2.5), 256*9000.0*SC/2*$sin(-2.5),
             256*20000.0*SC/2*$cos(1.3), 256*20000.0*SC/2*$sin(1.3), t, "R8 tone N256");
    drive_record(8, 40, 0, 1'b0);

    // R3: full-scale, N=65536, bin 0, exact
    for (int k = 0; k < 65536; k++) begin v_buf[k] = -32768; i_buf[k] = 32767; end
    push_exp(-32768.0*SC*65536.0, 0.0, SC*SC*65536.0, 0.0, 0.0, "R3 full scale");
    drive_record(16, 0, 0, 1'b1);

    repeat (4) @(negedge clk);
    check("scoreboard drained", real'(sb.size()), 0.0, 0.0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule